// File: doc/BRIEF.md
# Memory Rank Sparing Controller

This block decides, for each of two memory channels, when a rank with a failing record must be copied onto a spare rank. Each channel watches its per-rank corrected-error counts against a programmed threshold. When exactly one rank sits on that threshold and the channel is enabled, the block starts a copy. A rising edge on a force control also starts a copy, from a chosen rank. The copy is modelled as an address counter. It steps once for each copy-beat handshake from the data mover.

When the last address is copied, the channel enters its fail-over state. Every rank-map entry that named the failed rank is then rewritten to name the spare rank. Only one channel may start an automatic copy at a time, and channel 0 wins a tie. A losing channel starts once the winner's enable drops, but only if its own trigger still holds. Each channel reports copy-in-progress, fail-over-complete and threshold-reached. It also exposes the spare-rank register and the copy address.

Top module: `rank_spare_ctrl`

## Requirements
- R1: An enabled channel with a nonzero threshold starts a copy (busy high after the next clock edge, copy address 0) when exactly one rank's count equals the threshold. With zero or two or more equal ranks, or a threshold of 0, no copy starts.
- R2: If both channels would start an automatic copy at the same edge, only channel 0 starts.
- R3: An automatic start is held off while the other channel is enabled and is copying or in fail-over. The held-off channel starts at the first edge at which the other channel's enable is low, and only if its own trigger still holds then.
- R4: A forced copy starts at an edge where force is high, force was low at the previous edge, the channel is enabled and not copying. Its source is the forced-rank input. Force held high, or a new edge during a copy, has no effect.
- R5: Clearing enable during a copy returns the channel to idle with address 0. Re-enabling with the trigger valid restarts the copy at address 0.
- R6: A spare-rank write is ignored while the channel is copying. Otherwise the written value is visible after the next edge. The reset value is NUM_RANKS-1.
- R7: On completion, every rank-map entry equal to the source rank is replaced by the spare-rank value. Other entries keep their values.
- R8: The threshold-reached flag is high one edge after any rank count is greater than or equal to a nonzero threshold. It is low otherwise.
- R9: A rank whose count is above the threshold never starts a copy.
- R10: During a copy the address increments by one per beat and holds without one. The beat taken at address COPY_LEN-1 ends the copy and enters fail-over.
- R11: Fail-over-complete stays high until the channel's enable is low at an edge. Busy is high only while copying, and never together with fail-over-complete.
- R12: Synchronous reset clears busy, fail-over and the threshold flag, sets the address to 0, and sets the rank map to identity (entry e holds e mod NUM_RANKS).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | NUM_CH | Per-channel sparing enable |
| thresh | input | NUM_CH*CNT_W | Per-channel error threshold, 0 disables |
| err_cnt | input | NUM_CH*NUM_RANKS*CNT_W | Corrected-error count per channel and rank, rank r of channel c at (c*NUM_RANKS+r)*CNT_W |
| force_req | input | NUM_CH | Forced-copy request, acts on its rising edge |
| force_rank | input | NUM_CH*RANK_W | Source rank for a forced copy |
| spare_wr | input | NUM_CH | Spare-rank register write strobe |
| spare_wdata | input | NUM_CH*RANK_W | Spare-rank write value |
| beat | input | NUM_CH | Copy-beat handshake |
| copy_busy | output | NUM_CH | Copy in progress |
| failover_done | output | NUM_CH | Fail-over complete |
| thr_hit | output | NUM_CH | Threshold reached |
| copy_addr | output | NUM_CH*ADDR_W | Current copy address |
| spare_rank | output | NUM_CH*RANK_W | Spare-rank register |
| rank_map | output | NUM_CH*MAP_ENTRIES*RANK_W | Rank map, entry e of channel c at (c*MAP_ENTRIES+e)*RANK_W |

## Verification
Every status output is registered once, so each result is due one edge after the stimulus that causes it. Starts, spare writes, address steps, the map rewrite and the threshold flag all follow this rule. The bench drives inputs one nanosecond after a rising edge and reads the outputs at the same offset after the next edge. It never reads between the two. The arbitration hand-off happens at the very edge where the winner's enable is seen low, so the loser's busy is checked right after that edge.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_COPY = 2'd1,
    SP_DONE = 2'd2
  } sp_state_e;
endpackage

// File: rtl/spr_trigger.sv
module spr_trigger #(
  parameter int NUM_RANKS = 4,
  parameter int CNT_W     = 4,
  parameter int RANK_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       en,
  input  logic [CNT_W-1:0]           thresh,
  input  logic [NUM_RANKS*CNT_W-1:0] cnt,
  output logic                       trig,
  output logic [RANK_W-1:0]          trig_rank,
  output logic                       thr_hit
);
  logic [NUM_RANKS-1:0] eq_vec;
  logic [NUM_RANKS-1:0] ge_vec;
  logic                 armed;

  function automatic logic [RANK_W-1:0] low_rank(input logic [NUM_RANKS-1:0] v);
    low_rank = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--)
      if (v[i]) low_rank = RANK_W'(i);
  endfunction

  assign armed = (thresh != '0);

  always_comb begin
    for (int r = 0; r < NUM_RANKS; r++) begin
      eq_vec[r] = armed && (cnt[r*CNT_W +: CNT_W] == thresh);
      ge_vec[r] = armed && (cnt[r*CNT_W +: CNT_W] >= thresh);
    end
  end

  assign trig      = en && ($countones(eq_vec) == 1);
  assign trig_rank = low_rank(eq_vec);

  always_ff @(posedge clk) begin
    if (rst) thr_hit <= 1'b0;
    else     thr_hit <= |ge_vec;
  end
endmodule

// File: rtl/spr_arb.sv
module spr_arb #(
  parameter int NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] hold,
  output logic [NUM_CH-1:0] grant
);
  logic earlier;

  always_comb begin
    earlier = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      grant[c] = req[c] && !(|hold) && !earlier;
      earlier  = earlier | req[c];
    end
  end
endmodule

// File: rtl/spr_copy_ch.sv
module spr_copy_ch
  import spr_pkg::*;
#(
  parameter int NUM_RANKS   = 4,
  parameter int RANK_W      = 2,
  parameter int COPY_LEN    = 8,
  parameter int ADDR_W      = 3,
  parameter int MAP_ENTRIES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          en,
  input  logic                          auto_go,
  input  logic [RANK_W-1:0]             trig_rank,
  input  logic                          force_req,
  input  logic [RANK_W-1:0]             force_rank,
  input  logic                          spare_wr,
  input  logic [RANK_W-1:0]             spare_wdata,
  input  logic                          beat,
  output logic                          busy,
  output logic                          done,
  output logic                          idle,
  output logic                          hold,
  output logic                          force_go,
  output logic [ADDR_W-1:0]             addr,
  output logic [RANK_W-1:0]             spare_q,
  output logic [MAP_ENTRIES*RANK_W-1:0] map_q
);
  localparam int MAP_W = MAP_ENTRIES * RANK_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(COPY_LEN - 1);
  localparam logic [RANK_W-1:0] SPARE_DEF = RANK_W'(NUM_RANKS - 1);

  sp_state_e         state;
  logic              force_q;
  logic [RANK_W-1:0] src_q;
  logic              last_beat;

  function automatic logic [MAP_W-1:0] map_identity();
    for (int e = 0; e < MAP_ENTRIES; e++)
      map_identity[e*RANK_W +: RANK_W] = RANK_W'(e % NUM_RANKS);
  endfunction

  function automatic logic [MAP_W-1:0] remap(input logic [MAP_W-1:0] m,
                                             input logic [RANK_W-1:0] from,
                                             input logic [RANK_W-1:0] to);
    remap = m;
    for (int e = 0; e < MAP_ENTRIES; e++)
      if (m[e*RANK_W +: RANK_W] == from) remap[e*RANK_W +: RANK_W] = to;
  endfunction

  assign busy      = (state == SP_COPY);
  assign done      = (state == SP_DONE);
  assign idle      = (state == SP_IDLE);
  assign hold      = en && !idle;
  assign force_go  = en && force_req && !force_q && !busy;
  assign last_beat = busy && en && beat && (addr == LAST_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SP_IDLE;
      addr    <= '0;
      src_q   <= '0;
      force_q <= 1'b0;
      spare_q <= SPARE_DEF;
      map_q   <= map_identity();
    end else begin
      force_q <= force_req;
      if (spare_wr && !busy) spare_q <= spare_wdata;
      unique case (state)
        SP_IDLE: begin
          if (force_go || auto_go) begin
            state <= SP_COPY;
            addr  <= '0;
            src_q <= force_go ? force_rank : trig_rank;
          end
        end
        SP_COPY: begin
          if (!en) begin
            state <= SP_IDLE;
            addr  <= '0;
          end else if (last_beat) begin
            state <= SP_DONE;
            map_q <= remap(map_q, src_q, spare_q);
          end else if (beat) begin
            addr <= addr + 1'b1;
          end
        end
        SP_DONE: begin
          if (!en) begin
            state <= SP_IDLE;
            addr  <= '0;
          end else if (force_go) begin
            state <= SP_COPY;
            addr  <= '0;
            src_q <= force_rank;
          end
        end
        default: state <= SP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl #(
  parameter int NUM_CH      = 2,
  parameter int NUM_RANKS   = 4,
  parameter int CNT_W       = 4,
  parameter int COPY_LEN    = 8,
  parameter int MAP_ENTRIES = 4,
  localparam int RANK_W     = $clog2(NUM_RANKS),
  localparam int ADDR_W     = $clog2(COPY_LEN)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [NUM_CH-1:0]                    ch_en,
  input  logic [NUM_CH*CNT_W-1:0]              thresh,
  input  logic [NUM_CH*NUM_RANKS*CNT_W-1:0]    err_cnt,
  input  logic [NUM_CH-1:0]                    force_req,
  input  logic [NUM_CH*RANK_W-1:0]             force_rank,
  input  logic [NUM_CH-1:0]                    spare_wr,
  input  logic [NUM_CH*RANK_W-1:0]             spare_wdata,
  input  logic [NUM_CH-1:0]                    beat,
  output logic [NUM_CH-1:0]                    copy_busy,
  output logic [NUM_CH-1:0]                    failover_done,
  output logic [NUM_CH-1:0]                    thr_hit,
  output logic [NUM_CH*ADDR_W-1:0]             copy_addr,
  output logic [NUM_CH*RANK_W-1:0]             spare_rank,
  output logic [NUM_CH*MAP_ENTRIES*RANK_W-1:0] rank_map
);
  localparam int MAP_W = MAP_ENTRIES * RANK_W;

  logic [NUM_CH-1:0] trig;
  logic [NUM_CH-1:0] ch_idle;
  logic [NUM_CH-1:0] ch_hold;
  logic [NUM_CH-1:0] auto_req;
  logic [NUM_CH-1:0] auto_grant;
  logic [NUM_CH-1:0] force_go;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RANK_W-1:0] trig_rank;

    spr_trigger #(.NUM_RANKS(NUM_RANKS), .CNT_W(CNT_W), .RANK_W(RANK_W)) u_trig (
      .clk       (clk),
      .rst       (rst),
      .en        (ch_en[c]),
      .thresh    (thresh[c*CNT_W +: CNT_W]),
      .cnt       (err_cnt[c*NUM_RANKS*CNT_W +: NUM_RANKS*CNT_W]),
      .trig      (trig[c]),
      .trig_rank (trig_rank),
      .thr_hit   (thr_hit[c])
    );

    assign auto_req[c] = trig[c] && ch_idle[c];

    spr_copy_ch #(
      .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W), .COPY_LEN(COPY_LEN),
      .ADDR_W(ADDR_W), .MAP_ENTRIES(MAP_ENTRIES)
    ) u_copy (
      .clk         (clk),
      .rst         (rst),
      .en          (ch_en[c]),
      .auto_go     (auto_grant[c]),
      .trig_rank   (trig_rank),
      .force_req   (force_req[c]),
      .force_rank  (force_rank[c*RANK_W +: RANK_W]),
      .spare_wr    (spare_wr[c]),
      .spare_wdata (spare_wdata[c*RANK_W +: RANK_W]),
      .beat        (beat[c]),
      .busy        (copy_busy[c]),
      .done        (failover_done[c]),
      .idle        (ch_idle[c]),
      .hold        (ch_hold[c]),
      .force_go    (force_go[c]),
      .addr        (copy_addr[c*ADDR_W +: ADDR_W]),
      .spare_q     (spare_rank[c*RANK_W +: RANK_W]),
      .map_q       (rank_map[c*MAP_W +: MAP_W])
    );
  end

  spr_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req   (auto_req),
    .hold  (ch_hold),
    .grant (auto_grant)
  );
endmodule

// File: rtl/rank_spare_ctrl_chk.sv
module rank_spare_ctrl_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3,
  parameter int RANK_W = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_CH-1:0]          ch_en,
  input logic [NUM_CH-1:0]          spare_wr,
  input logic [NUM_CH-1:0]          force_req,
  input logic [NUM_CH-1:0]          beat,
  input logic [NUM_CH-1:0]          copy_busy,
  input logic [NUM_CH-1:0]          failover_done,
  input logic [NUM_CH*ADDR_W-1:0]   copy_addr,
  input logic [NUM_CH*RANK_W-1:0]   spare_rank,
  input logic [NUM_CH-1:0]          auto_grant,
  input logic [NUM_CH-1:0]          ch_hold
);
  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(auto_grant));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R3
    grant_no_holder_chk: assert property (@(posedge clk) disable iff (rst)
      auto_grant[c] |-> (ch_hold == '0));

    // R5
    abort_restart_chk: assert property (@(posedge clk) disable iff (rst)
      (copy_busy[c] && !ch_en[c]) |=> (!copy_busy[c] && copy_addr[c*ADDR_W +: ADDR_W] == '0));

    // R6
    spare_locked_chk: assert property (@(posedge clk) disable iff (rst)
      (copy_busy[c] && spare_wr[c]) |=> $stable(spare_rank[c*RANK_W +: RANK_W]));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (copy_busy[c] && ch_en[c] && !beat[c]) |=> $stable(copy_addr[c*ADDR_W +: ADDR_W]));

    // R10
    done_after_copy_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(failover_done[c]) |-> $past(copy_busy[c]));

    // R11
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (failover_done[c] && ch_en[c] && !force_req[c]) |=> failover_done[c]);

    // R11
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(copy_busy[c] && failover_done[c]));
  end
endmodule

bind rank_spare_ctrl rank_spare_ctrl_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .RANK_W(RANK_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ch_en         (ch_en),
  .spare_wr      (spare_wr),
  .force_req     (force_req),
  .beat          (beat),
  .copy_busy     (copy_busy),
  .failover_done (failover_done),
  .copy_addr     (copy_addr),
  .spare_rank    (spare_rank),
  .auto_grant    (auto_grant),
  .ch_hold       (ch_hold)
);

// File: tb/rank_spare_ctrl_tb.sv
`timescale 1ns/1ps
module rank_spare_ctrl_tb;
  localparam int NC = 2, NR = 4, CW = 4, CL = 8, ME = 4, RW = 2, AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0]       ch_en = '0, force_req = '0, spare_wr = '0, beat = '0;
  logic [NC*CW-1:0]    thresh = '0;
  logic [NC*NR*CW-1:0] err_cnt = '0;
  logic [NC*RW-1:0]    force_rank = '0, spare_wdata = '0;
  logic [NC-1:0]       copy_busy, failover_done, thr_hit;
  logic [NC*AW-1:0]    copy_addr;
  logic [NC*RW-1:0]    spare_rank;
  logic [NC*ME*RW-1:0] rank_map;

  int checks = 0, errors = 0;
  bit finished = 0;
  int exp_map [NC][ME];

  always #2 clk = ~clk;

  rank_spare_ctrl u_dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .thresh(thresh), .err_cnt(err_cnt),
    .force_req(force_req), .force_rank(force_rank), .spare_wr(spare_wr),
    .spare_wdata(spare_wdata), .beat(beat), .copy_busy(copy_busy),
    .failover_done(failover_done), .thr_hit(thr_hit), .copy_addr(copy_addr),
    .spare_rank(spare_rank), .rank_map(rank_map)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cnt(input int c, input int r, input int v);
    err_cnt[(c*NR + r)*CW +: CW] = CW'(v);
  endtask

  task automatic clr_cnt(input int c);
    for (int r = 0; r < NR; r++) set_cnt(c, r, 0);
  endtask

  function automatic int addr_of(input int c);
    return int'(copy_addr[c*AW +: AW]);
  endfunction

  task automatic model_remap(input int c, input int from, input int to);
    for (int e = 0; e < ME; e++) if (exp_map[c][e] == from) exp_map[c][e] = to;
  endtask

  task automatic chk_map(input int c, input string req);
    for (int e = 0; e < ME; e++)
      chk(int'(rank_map[(c*ME + e)*RW +: RW]), exp_map[c][e], req);
  endtask

  task automatic run_beats(input int c, input int n);
    for (int k = 0; k < n; k++) begin
      beat[c] = 1'b1; tick(); beat[c] = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < ME; e++) exp_map[c][e] = e % NR;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R12 reset state
    for (int c = 0; c < NC; c++) begin
      chk(copy_busy[c], 0, "R12 busy");
      chk(failover_done[c], 0, "R12 done");
      chk(thr_hit[c], 0, "R12 thr");
      chk(addr_of(c), 0, "R12 addr");
      chk(int'(spare_rank[c*RW +: RW]), NR - 1, "R6 spare reset");
      chk_map(c, "R12 map");
    end

    // R1 / R8 sweep over every count pattern of values 0..3, threshold 2
    thresh[0 +: CW] = 2;
    for (int p = 0; p < 256; p++) begin
      int m, ge;
      m = 0; ge = 0;
      for (int r = 0; r < NR; r++) begin
        int v;
        v = (p >> (2*r)) & 3;
        set_cnt(0, r, v);
        if (v == 2) m++;
        if (v >= 2) ge = 1;
      end
      ch_en[0] = 1'b1;
      tick();
      chk(copy_busy[0], (m == 1) ? 1 : 0, "R1 trigger");
      chk(thr_hit[0], ge, "R8 thr");
      ch_en[0] = 1'b0;
      tick();
    end
    // R1 threshold 0 disables
    thresh[0 +: CW] = 0; clr_cnt(0); ch_en[0] = 1'b1;
    tick(); chk(copy_busy[0], 0, "R1 zero thr"); chk(thr_hit[0], 0, "R8 zero thr");
    ch_en[0] = 1'b0; tick();

    // R10 / R6 / R7 / R11 full copy on channel 0 from rank 1
    thresh[0 +: CW] = 2; set_cnt(0, 1, 2); ch_en[0] = 1'b1;
    tick();
    chk(copy_busy[0], 1, "R1 start"); chk(addr_of(0), 0, "R10 start addr");
    spare_wr[0] = 1'b1; spare_wdata[0 +: RW] = 0; tick(); spare_wr[0] = 1'b0;
    chk(int'(spare_rank[0 +: RW]), 3, "R6 locked");
    for (int k = 0; k < CL; k++) begin
      beat[0] = 1'b1; tick(); beat[0] = 1'b0;
      if (k < CL - 1) begin
        chk(addr_of(0), k + 1, "R10 step");
        tick();
        chk(addr_of(0), k + 1, "R10 hold");
      end
    end
    chk(failover_done[0], 1, "R10 done"); chk(copy_busy[0], 0, "R11 busy low");
    model_remap(0, 1, 3);
    chk_map(0, "R7 remap");
    repeat (3) tick();
    chk(failover_done[0], 1, "R11 sticky");
    spare_wr[0] = 1'b1; spare_wdata[0 +: RW] = 1; tick(); spare_wr[0] = 1'b0;
    chk(int'(spare_rank[0 +: RW]), 1, "R6 accepted");
    ch_en[0] = 1'b0; tick();
    chk(failover_done[0], 0, "R11 clear");
    clr_cnt(0);

    // R2 / R3 priority and hand-off
    set_cnt(0, 2, 2); thresh[CW +: CW] = 4; set_cnt(1, 0, 4);
    ch_en = 2'b11; tick();
    chk(copy_busy[0], 1, "R2 ch0 wins"); chk(copy_busy[1], 0, "R2 ch1 waits");
    repeat (3) tick();
    chk(copy_busy[1], 0, "R3 held off");
    ch_en[0] = 1'b0; tick();
    chk(copy_busy[0], 0, "R3 ch0 aborted"); chk(copy_busy[1], 1, "R3 ch1 starts");

    // R5 restart from the first address on channel 1
    run_beats(1, 2);
    chk(addr_of(1), 2, "R5 progress");
    ch_en[1] = 1'b0; tick();
    chk(copy_busy[1], 0, "R5 abort"); chk(addr_of(1), 0, "R5 addr reset");
    ch_en[1] = 1'b1; tick();
    chk(copy_busy[1], 1, "R5 restart"); chk(addr_of(1), 0, "R5 from zero");
    ch_en[1] = 1'b0; tick();

    // R3 loser without a valid trigger stays idle
    ch_en = 2'b11; tick();
    chk(copy_busy[0], 1, "R3 winner"); chk(copy_busy[1], 0, "R3 loser");
    set_cnt(1, 0, 0);
    ch_en[0] = 1'b0; tick();
    chk(copy_busy[1], 0, "R3 trigger gone");
    ch_en = 2'b00; tick();
    clr_cnt(0);

    // R4 forced copy on channel 0 from rank 2
    ch_en[0] = 1'b1; tick();
    chk(copy_busy[0], 0, "R4 no trigger");
    force_rank[0 +: RW] = 2; force_req[0] = 1'b1; tick();
    chk(copy_busy[0], 1, "R4 force start");
    run_beats(0, 1);
    tick();
    chk(addr_of(0), 1, "R4 level ignored");
    force_req[0] = 1'b0; tick(); force_req[0] = 1'b1; tick();
    chk(addr_of(0), 1, "R4 edge in copy ignored"); chk(copy_busy[0], 1, "R4 still busy");
    force_req[0] = 1'b0;
    run_beats(0, CL - 1);
    chk(failover_done[0], 1, "R4 done");
    model_remap(0, 2, 1);
    chk_map(0, "R7 forced remap");
    ch_en[0] = 1'b0; tick();
    force_req[0] = 1'b1; tick();
    chk(copy_busy[0], 0, "R4 disabled force");
    force_req[0] = 1'b0; tick();

    // R9 / R8 count above threshold
    thresh[CW +: CW] = 3; set_cnt(1, 3, 5); ch_en[1] = 1'b1; tick();
    chk(copy_busy[1], 0, "R9 above no trigger"); chk(thr_hit[1], 1, "R8 above");
    tick(); chk(copy_busy[1], 0, "R9 still idle");
    set_cnt(1, 3, 2); tick();
    chk(thr_hit[1], 0, "R8 dropped"); chk(copy_busy[1], 0, "R9 below");
    chk_map(1, "R7 ch1 untouched");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule